// File: doc/BRIEF.md
# DMA Command Sequencer for a Flash Controller Control Plane

This block listens to the command writes that software sends to the high-level control plane of a flash controller and builds one DMA descriptor from four of them. Each write brings a 28-bit address and a 32-bit data word. The address holds a two-bit access-mode field, a two-bit bank field and a 24-bit payload. The data word holds a tag that says which step of the sequence the write is.

The steps must arrive in a fixed order. Step 1 gives the page number, the direction and the page count. Steps 2 and 3 give the upper and lower 16-bit halves of the memory address. Step 4 gives the burst length and whether an interrupt is wanted at completion. When step 4 is taken, the assembled descriptor appears on a valid/ready output and stays there until it is accepted.

A write with a wrong tag, or with a bank other than the bank given in step 1, aborts the sequence and raises a one-cycle error pulse. The DMA path has a separate enable input. Writes are only taken while it is high, and dropping it discards a partly built sequence.

Top module: `dma_cmd_seq`

## Requirements
- R1: After an active-low reset, `desc_valid` and `seq_err` are both 0.
- R2: A write is ignored (no error, no change of sequence state) unless `wr_valid` and `dma_en` are both 1 and the access-mode field `wr_addr[27:26]` equals 2'b10.
- R3: Step 1 has `wr_data[31:16]`=0 and `wr_data[15:9]`=7'b0010000. `wr_data[8]` is the direction (1 = toward flash). `wr_data[7:0]` is the page count. `wr_addr[PAGE_W-1:0]` is the page number. `wr_addr[25:24]` is the bank of the sequence.
- R4: Step 2 has `wr_data`=32'h00002200. `wr_addr[23:8]` becomes `desc_addr[31:16]`.
- R5: Step 3 has `wr_data`=32'h00002300. `wr_addr[23:8]` becomes `desc_addr[15:0]`.
- R6: Step 4 has `wr_data`=32'h00002400. `wr_addr[15:8]` is the burst length in bytes and `wr_addr[16]` requests an interrupt (0x14000 gives a 64-byte burst with interrupt). `desc_valid` is 1 from the cycle after the step-4 write.
- R7: A taken write whose data is not the tag of the expected next step gives `seq_err`=1 for exactly the following cycle. The sequence then waits for step 1 again, and the offending write does not start a new sequence.
- R8: With `CHECK_BANK`=1, a step 2–4 write whose bank differs from the step-1 bank is a sequence error as in R7.
- R9: While `desc_valid`=1 and `desc_ready`=0, the descriptor outputs hold their values.
- R10: A step-1 write while `desc_valid`=1 is refused: it raises no error and does not start a sequence. One `desc_ready` cycle clears `desc_valid`.
- R11: Taking `dma_en` to 0 discards a partial sequence without raising `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA path enable |
| wr_valid | input | 1 | Command write strobe |
| wr_addr | input | 28 | Write address: mode, bank, payload |
| wr_data | input | 32 | Write data with step tag |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Descriptor accepted |
| desc_bank | output | 2 | Bank of the request |
| desc_page | output | PAGE_W | Page number |
| desc_write | output | 1 | 1 = transfer toward flash |
| desc_count | output | 8 | Page count |
| desc_addr | output | 32 | Memory address |
| desc_burst | output | 8 | Burst length in bytes |
| desc_irq | output | 1 | Interrupt on completion requested |
| seq_err | output | 1 | One-cycle pulse on an ordering or bank error |

## Verification
The bench builds the block with `PAGE_W`=16 and `CHECK_BANK`=1. The narrower page field makes truncation of the step-1 payload visible: payload bits 23:16 must not reach `desc_page`. Enabling the bank check brings the bank-mismatch abort within reach. The refused step-1 write is shown to have no effect by sending step 2 next and expecting an error, since a sequence that had started would have taken that step 2.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
   // classification of one command write
   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_S1   = 3'd1,
      K_S2   = 3'd2,
      K_S3   = 3'd3,
      K_S4   = 3'd4,
      K_BAD  = 3'd5
   } kind_t;

   // which step the tracker waits for
   typedef enum logic [1:0] {
      W_S1 = 2'd0,
      W_S2 = 2'd1,
      W_S3 = 2'd2,
      W_S4 = 2'd3
   } phase_t;

   localparam int          PAYLOAD_W  = 24;
   localparam int          BANK_W     = 2;
   localparam int          MODE_W     = 2;
   localparam int          WADDR_W    = PAYLOAD_W + BANK_W + MODE_W;
   localparam int          HALF_W     = 16;
   localparam int          MADDR_W    = 2 * HALF_W;
   localparam int          CNT_W      = 8;
   localparam logic [1:0]  PLANE_CTRL = 2'b10;
   localparam logic [6:0]  TAG1_HI    = 7'h10;
   localparam logic [7:0]  TAG2       = 8'h22;
   localparam logic [7:0]  TAG3       = 8'h23;
   localparam logic [7:0]  TAG4       = 8'h24;
endpackage

// File: rtl/dmaseq_decode.sv
module dmaseq_decode
   import dmaseq_pkg::*;
(
   input  logic                 wr_valid,
   input  logic                 dma_en,
   input  logic [WADDR_W-1:0]   wr_addr,
   input  logic [31:0]          wr_data,
   output kind_t                kind,
   output logic [BANK_W-1:0]    bank,
   output logic [PAYLOAD_W-1:0] payload
);
   localparam int BANK_LSB = PAYLOAD_W;
   localparam int MODE_LSB = BANK_LSB + BANK_W;

   logic taken;
   logic hi_zero;

   assign taken   = wr_valid && dma_en &&
                    (wr_addr[MODE_LSB +: MODE_W] == PLANE_CTRL);
   assign hi_zero = (wr_data[31:16] == 16'h0000);
   assign bank    = wr_addr[BANK_LSB +: BANK_W];
   assign payload = wr_addr[PAYLOAD_W-1:0];

   always_comb begin
      kind = K_NONE;
      if (taken) begin
         if (!hi_zero)
            kind = K_BAD;
         else if (wr_data[15:9] == TAG1_HI)
            kind = K_S1;
         else if (wr_data[7:0] != 8'h00)
            kind = K_BAD;
         else if (wr_data[15:8] == TAG2)
            kind = K_S2;
         else if (wr_data[15:8] == TAG3)
            kind = K_S3;
         else if (wr_data[15:8] == TAG4)
            kind = K_S4;
         else
            kind = K_BAD;
      end
   end
endmodule

// File: rtl/dmaseq_collect.sv
module dmaseq_collect
   import dmaseq_pkg::*;
#(
   parameter int PAGE_W     = 24,
   parameter bit CHECK_BANK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dma_en,
   input  logic                 pending,
   input  kind_t                kind,
   input  logic [BANK_W-1:0]    bank,
   input  logic [PAYLOAD_W-1:0] payload,
   input  logic [8:0]           dlow,
   output logic                 load,
   output logic                 seq_err,
   output phase_t               phase,
   output logic [BANK_W-1:0]    c_bank,
   output logic [PAGE_W-1:0]    c_page,
   output logic                 c_write,
   output logic [CNT_W-1:0]     c_count,
   output logic [MADDR_W-1:0]   c_addr,
   output logic [7:0]           c_burst,
   output logic                 c_irq
);
   phase_t            phase_n;
   logic              err_n;
   logic              cap1, cap2, cap3;
   logic              bank_ok;
   kind_t             want;
   logic [HALF_W-1:0] hi_q, lo_q;

   generate
      if (CHECK_BANK) begin : g_bank_chk
         assign bank_ok = (bank == c_bank);
      end else begin : g_bank_free
         assign bank_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (phase)
         W_S2:    want = K_S2;
         W_S3:    want = K_S3;
         W_S4:    want = K_S4;
         default: want = K_S1;
      endcase
   end

   always_comb begin
      phase_n = phase;
      err_n   = 1'b0;
      load    = 1'b0;
      cap1    = 1'b0;
      cap2    = 1'b0;
      cap3    = 1'b0;
      if (!dma_en) begin
         phase_n = W_S1;
      end else if (kind != K_NONE) begin
         if (phase == W_S1) begin
            if (kind == K_S1) begin
               if (!pending) begin
                  cap1    = 1'b1;
                  phase_n = W_S2;
               end
            end else begin
               err_n = 1'b1;
            end
         end else if (kind == want && bank_ok) begin
            unique case (phase)
               W_S2: begin cap2 = 1'b1; phase_n = W_S3; end
               W_S3: begin cap3 = 1'b1; phase_n = W_S4; end
               default: begin load = 1'b1; phase_n = W_S1; end
            endcase
         end else begin
            err_n   = 1'b1;
            phase_n = W_S1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= W_S1;
         seq_err <= 1'b0;
         c_bank  <= '0;
         c_page  <= '0;
         c_write <= 1'b0;
         c_count <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         phase   <= phase_n;
         seq_err <= err_n;
         if (cap1) begin
            c_bank  <= bank;
            c_page  <= payload[PAGE_W-1:0];
            c_write <= dlow[8];
            c_count <= dlow[7:0];
         end
         if (cap2) hi_q <= payload[23:8];
         if (cap3) lo_q <= payload[23:8];
      end
   end

   assign c_addr  = {hi_q, lo_q};
   assign c_burst = payload[15:8];
   assign c_irq   = payload[16];
endmodule

// File: rtl/dmaseq_out.sv
module dmaseq_out
   import dmaseq_pkg::*;
#(
   parameter int PAGE_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BANK_W-1:0]  i_bank,
   input  logic [PAGE_W-1:0]  i_page,
   input  logic               i_write,
   input  logic [CNT_W-1:0]   i_count,
   input  logic [MADDR_W-1:0] i_addr,
   input  logic [7:0]         i_burst,
   input  logic               i_irq,
   input  logic               ready,
   output logic               valid,
   output logic [BANK_W-1:0]  o_bank,
   output logic [PAGE_W-1:0]  o_page,
   output logic               o_write,
   output logic [CNT_W-1:0]   o_count,
   output logic [MADDR_W-1:0] o_addr,
   output logic [7:0]         o_burst,
   output logic               o_irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         o_bank  <= '0;
         o_page  <= '0;
         o_write <= 1'b0;
         o_count <= '0;
         o_addr  <= '0;
         o_burst <= '0;
         o_irq   <= 1'b0;
      end else if (load) begin
         valid   <= 1'b1;
         o_bank  <= i_bank;
         o_page  <= i_page;
         o_write <= i_write;
         o_count <= i_count;
         o_addr  <= i_addr;
         o_burst <= i_burst;
         o_irq   <= i_irq;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
   import dmaseq_pkg::*;
#(
   parameter int PAGE_W     = 24,
   parameter bit CHECK_BANK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_en,
   input  logic              wr_valid,
   input  logic [27:0]       wr_addr,
   input  logic [31:0]       wr_data,
   output logic              desc_valid,
   input  logic              desc_ready,
   output logic [1:0]        desc_bank,
   output logic [PAGE_W-1:0] desc_page,
   output logic              desc_write,
   output logic [7:0]        desc_count,
   output logic [31:0]       desc_addr,
   output logic [7:0]        desc_burst,
   output logic              desc_irq,
   output logic              seq_err
);
   generate
      if (PAGE_W < 1 || PAGE_W > PAYLOAD_W) begin : g_bad_page_w
         $error("dma_cmd_seq: PAGE_W must lie in 1..24");
      end
      if (WADDR_W != 28) begin : g_bad_addr_w
         $error("dma_cmd_seq: address layout must total 28 bits");
      end
   endgenerate

   kind_t                kind;
   logic [BANK_W-1:0]    bank;
   logic [PAYLOAD_W-1:0] payload;
   logic                 load;
   phase_t               seq_phase;
   logic [BANK_W-1:0]    c_bank;
   logic [PAGE_W-1:0]    c_page;
   logic                 c_write;
   logic [CNT_W-1:0]     c_count;
   logic [MADDR_W-1:0]   c_addr;
   logic [7:0]           c_burst;
   logic                 c_irq;

   dmaseq_decode u_decode (
      .wr_valid (wr_valid),
      .dma_en   (dma_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .kind     (kind),
      .bank     (bank),
      .payload  (payload)
   );

   dmaseq_collect #(.PAGE_W(PAGE_W), .CHECK_BANK(CHECK_BANK)) u_collect (
      .clk     (clk),
      .rst_n   (rst_n),
      .dma_en  (dma_en),
      .pending (desc_valid),
      .kind    (kind),
      .bank    (bank),
      .payload (payload),
      .dlow    (wr_data[8:0]),
      .load    (load),
      .seq_err (seq_err),
      .phase   (seq_phase),
      .c_bank  (c_bank),
      .c_page  (c_page),
      .c_write (c_write),
      .c_count (c_count),
      .c_addr  (c_addr),
      .c_burst (c_burst),
      .c_irq   (c_irq)
   );

   dmaseq_out #(.PAGE_W(PAGE_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .i_bank  (c_bank),
      .i_page  (c_page),
      .i_write (c_write),
      .i_count (c_count),
      .i_addr  (c_addr),
      .i_burst (c_burst),
      .i_irq   (c_irq),
      .ready   (desc_ready),
      .valid   (desc_valid),
      .o_bank  (desc_bank),
      .o_page  (desc_page),
      .o_write (desc_write),
      .o_count (desc_count),
      .o_addr  (desc_addr),
      .o_burst (desc_burst),
      .o_irq   (desc_irq)
   );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
   parameter int PAGE_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_en,
   input logic              wr_valid,
   input logic [27:0]       wr_addr,
   input logic [31:0]       wr_data,
   input logic              desc_valid,
   input logic              desc_ready,
   input logic [PAGE_W-1:0] desc_page,
   input logic [31:0]       desc_addr,
   input logic [7:0]        desc_count,
   input logic [7:0]        desc_burst,
   input logic              seq_err,
   input logic [1:0]        seq_phase
);
   logic step1_seen;
   assign step1_seen = wr_valid && dma_en && (wr_addr[27:26] == 2'b10) &&
                       (wr_data[31:16] == 16'h0) && (wr_data[15:9] == 7'h10);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!desc_valid && !seq_err));

   assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_valid || !dma_en) |=> (!seq_err && !$rose(desc_valid)));

   assert_other_plane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr[27:26] != 2'b10) |=> (!seq_err && !$rose(desc_valid)));

   assert_err_not_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> !$rose(desc_valid));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !desc_ready) |=>
         (desc_valid && $stable(desc_addr) && $stable(desc_page) &&
          $stable(desc_count) && $stable(desc_burst)));

   assert_no_partial_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (seq_phase == 2'd0));

   assert_refuse_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && step1_seen) |=> (!seq_err && seq_phase == 2'd0));

   assert_drop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |=> (seq_phase == 2'd0 && !seq_err));
endmodule

bind dma_cmd_seq dmaseq_chk #(.PAGE_W(PAGE_W)) u_dmaseq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dma_en     (dma_en),
   .wr_valid   (wr_valid),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .desc_valid (desc_valid),
   .desc_ready (desc_ready),
   .desc_page  (desc_page),
   .desc_addr  (desc_addr),
   .desc_count (desc_count),
   .desc_burst (desc_burst),
   .seq_err    (seq_err),
   .seq_phase  (seq_phase)
);

// File: tb/test_dma_cmd_seq.sv
`timescale 1ns/1ps
module test_dma_cmd_seq;
   localparam int PW = 16;
   localparam int NV = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dma_en = 1'b0;
   logic          wr_valid = 1'b0;
   logic [27:0]   wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          desc_ready = 1'b0;
   logic          desc_valid, desc_write, desc_irq, seq_err;
   logic [1:0]    desc_bank;
   logic [PW-1:0] desc_page;
   logic [7:0]    desc_count, desc_burst;
   logic [31:0]   desc_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dma_cmd_seq #(.PAGE_W(PW), .CHECK_BANK(1'b1)) i_dma_cmd_seq (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .desc_valid(desc_valid),
      .desc_ready(desc_ready), .desc_bank(desc_bank), .desc_page(desc_page),
      .desc_write(desc_write), .desc_count(desc_count), .desc_addr(desc_addr),
      .desc_burst(desc_burst), .desc_irq(desc_irq), .seq_err(seq_err)
   );

   // {address, data, expected seq_err, expected desc_valid}
   localparam logic [61:0] VEC [NV] = '{
      {28'h8000005, 32'h00002104, 1'b0, 1'b0},
      {28'h8123400, 32'h00002200, 1'b0, 1'b0},
      {28'h8567800, 32'h00002300, 1'b0, 1'b0},
      {28'h8014000, 32'h00002400, 1'b0, 1'b1},
      {28'h8000000, 32'h00002300, 1'b1, 1'b0},
      {28'h8000007, 32'h00002001, 1'b0, 1'b0},
      {28'h8000000, 32'h00002001, 1'b1, 1'b0},
      {28'h8000000, 32'h00002200, 1'b1, 1'b0},
      {28'h4000000, 32'h00002001, 1'b0, 1'b0},
      {28'h8000003, 32'h00002001, 1'b0, 1'b0},
      {28'h9000000, 32'h00002200, 1'b1, 1'b0},
      {28'h8000003, 32'h00002001, 1'b0, 1'b0},
      {28'h8000000, 32'h00002201, 1'b1, 1'b0},
      {28'h8000003, 32'h00012001, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [27:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic take();
      @(negedge clk);
      desc_ready = 1'b1;
      @(negedge clk);
      desc_ready = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid after reset", {31'b0, desc_valid}, 32'd0);
      chk("R1 err after reset", {31'b0, seq_err}, 32'd0);
      rst_n = 1'b1;
      dma_en = 1'b1;

      // table walk: ordering, tags, plane filter, bank match (R2 R3 R6 R7 R8)
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][61:34], VEC[i][33:2]);
         chk($sformatf("R7 table err entry %0d", i), {31'b0, seq_err}, {31'b0, VEC[i][1]});
         chk($sformatf("R6 table valid entry %0d", i), {31'b0, desc_valid}, {31'b0, VEC[i][0]});
         if (VEC[i][0]) take();
      end

      // full sequence on bank 2, read, truncated page
      wr(28'hAABCD12, 32'h00002010);
      wr(28'hABEEF00, 32'h00002200);
      wr(28'hA004200, 32'h00002300);
      chk("R6 not valid before step 4", {31'b0, desc_valid}, 32'd0);
      wr(28'hA008000, 32'h00002400);
      chk("R6 valid after step 4", {31'b0, desc_valid}, 32'd1);
      chk("R3 bank", {30'b0, desc_bank}, 32'd2);
      chk("R3 page truncated", {16'b0, desc_page}, 32'h0000CD12);
      chk("R3 direction read", {31'b0, desc_write}, 32'd0);
      chk("R3 count", {24'b0, desc_count}, 32'h10);
      chk("R4 R5 memory address", desc_addr, 32'hBEEF0042);
      chk("R6 burst", {24'b0, desc_burst}, 32'h80);
      chk("R6 irq off", {31'b0, desc_irq}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R9 held valid", {31'b0, desc_valid}, 32'd1);
      chk("R9 held addr", desc_addr, 32'hBEEF0042);
      // step 1 while pending is refused
      wr(28'hA000001, 32'h00002101);
      chk("R10 no error on refused step 1", {31'b0, seq_err}, 32'd0);
      chk("R10 page unchanged", {16'b0, desc_page}, 32'h0000CD12);
      take();
      chk("R10 valid cleared by ready", {31'b0, desc_valid}, 32'd0);
      wr(28'hA000000, 32'h00002200);
      chk("R10 refused step 1 started nothing", {31'b0, seq_err}, 32'd1);

      // second descriptor: write direction, irq on
      wr(28'h8000009, 32'h00002102);
      wr(28'h8000100, 32'h00002200);
      wr(28'h8000200, 32'h00002300);
      wr(28'h8014000, 32'h00002400);
      chk("R3 direction write", {31'b0, desc_write}, 32'd1);
      chk("R6 irq on 64-byte burst", {24'b0, desc_burst, desc_irq, 7'b0}, {24'h0, 8'h40, 1'b1, 7'b0});
      chk("R4 R5 address halves", desc_addr, 32'h00010002);
      take();

      // enable low: writes ignored
      dma_en = 1'b0;
      wr(28'h8000000, 32'h00002200);
      chk("R2 no error while disabled", {31'b0, seq_err}, 32'd0);
      wr(28'h8000001, 32'h00002001);
      dma_en = 1'b1;
      wr(28'h8000000, 32'h00002200);
      chk("R2 disabled step 1 not taken", {31'b0, seq_err}, 32'd1);

      // dropping enable mid sequence
      wr(28'h8000001, 32'h00002001);
      wr(28'h8000100, 32'h00002200);
      @(negedge clk);
      dma_en = 1'b0;
      @(negedge clk);
      dma_en = 1'b1;
      chk("R11 no error on drop", {31'b0, seq_err}, 32'd0);
      wr(28'h8000200, 32'h00002300);
      chk("R11 partial sequence discarded", {31'b0, seq_err}, 32'd1);
      chk("R11 no descriptor", {31'b0, desc_valid}, 32'd0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule